// File: doc/BRIEF.md
# Comparator edge interrupt controller

This block is the control and status register that sits beside an on-chip analog comparator. The comparator result arrives with no timing relation to the system clock. The block passes it through a synchronizer and watches the synchronized value for an event. Software picks the event type: any change, a falling edge or a rising edge. When that event occurs, a sticky flag is set. An interrupt request goes out while that flag, a local enable and the processor's global interrupt-enable bit are all high.

Software reaches the block through a single byte-wide register. The register has these fields:
- a two-bit event selector in bits 1:0,
- a reserved bit 2 that always reads zero,
- the local enable in bit 3,
- the flag in bit 4,
- a read-only view of the synchronized comparator value in bit 5,
- bits 7:6, which read zero.

The flag clears in two ways: when the interrupt vector is taken, or when software writes a one to bit 4. Because clearing works by writing a one, a read-modify-write of any other field writes back a set flag as one and clears it. The block keeps that behaviour on purpose.

Top module: `cmp_evt_irq`

## Requirements
- R1: After reset, `rdata` reads 0x00 and `irq` is low.
- R2: With selector 00, a change of the synchronized comparator value in either direction sets the flag (bit 4). The flag reads one two clock edges after the first edge that samples the new `cmp_in`.
- R3: With selector 10, only a one-to-zero change sets the flag. A rising change leaves it unchanged.
- R4: With selector 11, only a zero-to-one change sets the flag. A falling change leaves it unchanged.
- R5: Selector 01 is reserved: no comparator activity sets the flag while it is selected.
- R6: Bits 2, 7 and 6 always read zero, whatever is written to them. Bit 5 reads the synchronized comparator value, and a write does not change it.
- R7: `irq` is high exactly when the flag, the enable (bit 3) and `gie` are all one.
- R8: A cycle with `vec_ack` high clears the flag.
- R9: A write with bit 4 at one clears the flag, and a write with bit 4 at zero leaves it as it was. Writing back a read value that has the flag set therefore clears the flag.
- R10: When a selected event and a clear (acknowledge or write-one) occur at the same edge, the flag ends up set.
- R11: A selected event sets the flag even while the enable is zero; `irq` then stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_in | input | 1 | Raw comparator output, asynchronous |
| gie | input | 1 | Processor global interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Register write data |
| vec_ack | input | 1 | Pulses when the interrupt vector is taken |
| rdata | output | 8 | Register read value |
| irq | output | 1 | Interrupt request |

## Verification
A change on `cmp_in` appears in bit 5 after two clock edges, and it sets the flag on the third edge. Register writes and acknowledges take effect on the edge that samples them, and `irq` follows the register contents combinationally. The bench keeps a history queue of sampled `cmp_in` values and a behavioural register image. It drives inputs just after the falling edge and compares `rdata` and `irq` against that image at every falling edge, so each result is checked in the first cycle it is due. It also places acknowledges and writes on exactly the edge of a detected event, to exercise the set-wins rule.

// File: rtl/cmp_evt_irq.sv
module cmp_evt_irq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_in,
  input  logic       gie,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       vec_ack,
  output logic [7:0] rdata,
  output logic       irq
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] smp_q;
  logic [1:0]       sel_q;
  logic             en_q;
  logic             flag_q;
  logic             cur, prv, evt, clr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) smp_q <= '0;
    else        smp_q <= {smp_q[CHAIN-2:0], cmp_in};

  assign cur = smp_q[CHAIN-2];
  assign prv = smp_q[CHAIN-1];

  always_comb begin
    unique case (sel_q)
      2'b00:   evt = cur ^ prv;
      2'b10:   evt = prv & ~cur;
      2'b11:   evt = cur & ~prv;
      default: evt = 1'b0;
    endcase
  end

  assign clr = vec_ack | (wr_en & wdata[4]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_q  <= 2'b00;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_en) begin
        sel_q <= wdata[1:0];
        en_q  <= wdata[3];
      end
      if (evt)      flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end

  assign rdata = {2'b00, cur, flag_q, en_q, 1'b0, sel_q};
  assign irq   = flag_q & en_q & gie;
endmodule

module cmp_evt_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       gie,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic       vec_ack,
  input logic [7:0] rdata,
  input logic       irq,
  input logic       evt
);
  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (rdata[4] & rdata[3] & gie));
  // R6
  zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[2] == 1'b0 && rdata[7:6] == 2'b00);
  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && !evt) |=> !rdata[4]);
  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> rdata[4]);
  // R9
  zero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[4] && !vec_ack && rdata[4]) |=> rdata[4]);
  // R5
  reserved_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[1:0] == 2'b01 && !rdata[4]) |=> !rdata[4]);
endmodule

bind cmp_evt_irq cmp_evt_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gie(gie), .wr_en(wr_en), .wdata(wdata),
  .vec_ack(vec_ack), .rdata(rdata), .irq(irq), .evt(evt)
);

// File: tb/sim_cmp_evt_irq.sv
module sim_cmp_evt_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_in = 1'b0, gie = 1'b0, wr_en = 1'b0, vec_ack = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0, errors = 0;
  string phase = "R1";

  bit   hist[$];
  bit [1:0] m_sel;
  bit   m_en, m_flag;

  always #2 clk = ~clk;

  cmp_evt_irq u0 (.clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .gie(gie),
    .wr_en(wr_en), .wdata(wdata), .vec_ack(vec_ack), .rdata(rdata), .irq(irq));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{0, 0, 0};
      m_sel = 0; m_en = 0; m_flag = 0;
    end else begin
      bit now_v, old_v, hit;
      now_v = hist[hist.size()-2];
      old_v = hist[hist.size()-3];
      case (m_sel)
        2'd0: hit = (now_v != old_v);
        2'd2: hit = old_v && !now_v;
        2'd3: hit = !old_v && now_v;
        default: hit = 0;
      endcase
      if (hit) m_flag = 1;
      else if (vec_ack || (wr_en && wdata[4])) m_flag = 0;
      if (wr_en) begin m_sel = wdata[1:0]; m_en = wdata[3]; end
      hist.push_back(cmp_in);
      if (hist.size() > 8) void'(hist.pop_front());
    end
  end

  always @(negedge clk) if (rst_n) begin
    logic [7:0] exp_r;
    logic exp_i;
    exp_r = {2'b00, hist[hist.size()-2], m_flag, m_en, 1'b0, m_sel};
    exp_i = m_flag && m_en && gie;
    checks++;
    if (rdata !== exp_r) begin
      errors++;
      $display("FAIL %s rdata actual=%h expected=%h", phase, rdata, exp_r);
    end
    checks++;
    if (irq !== exp_i) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", phase, irq, exp_i);
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wdata = d; step(); wr_en = 0; wdata = '0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #50000;
    errors++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    step(3); rst_n = 1; phase = "R1"; step(3);
    gie = 1;
    phase = "R2"; wr(8'h08); cmp_in = 1; step(5);
    phase = "R8"; vec_ack = 1; step(); vec_ack = 0; step(2);
    phase = "R2"; cmp_in = 0; step(5);
    phase = "R9"; wr(8'h18); step(2);
    phase = "R3"; wr(8'h0A); cmp_in = 1; step(5); cmp_in = 0; step(5);
    phase = "R9"; wr(rdata | 8'h01); step(3);
    phase = "R4"; cmp_in = 0; step(4); cmp_in = 1; step(5);
    phase = "R9"; wr(8'h0B); step(2);
    phase = "R7"; gie = 0; step(2); gie = 1; step(2); wr(8'h1B); step(2);
    phase = "R11"; wr(8'h03); cmp_in = 0; step(4); cmp_in = 1; step(5);
    wr(8'h13); step(2);
    phase = "R5"; wr(8'h09);
    for (int k = 0; k < 6; k++) begin cmp_in = ~cmp_in; step(3); end
    step(2);
    phase = "R6"; wr(8'hE4); step(2); wr(8'hFF); step(3);
    phase = "R10"; wr(8'h08); cmp_in = ~cmp_in; step(2);
    vec_ack = 1; step(); vec_ack = 0; step(3);
    vec_ack = 1; step(); vec_ack = 0; step(2);
    cmp_in = ~cmp_in; step(2); wr(8'h18); step(3);
    phase = "R3"; wr(8'h0A); cmp_in = 1; step(1); wr(8'h0B); step(4);
    finish_run();
  end
endmodule